// File: doc/BRIEF.md
# Video Encoder Configuration Write Port

This block receives configuration writes for a video encoder's control register bank. The bank spans sub-addresses 70h through 87h. An external host writes it through either a two-wire I2C slave or a chip-select framed SPI slave. Both paths decode the same one-byte device ID, which is chosen by a select pin. Both paths also feed one shared sub-address pointer. That pointer steps by one after every data byte, so a single transaction can fill a run of consecutive registers.

All bus inputs are oversampled on the system clock. The register contents are driven in parallel to the encoder datapath. A one-cycle write strobe, together with the written sub-address, marks each accepted write. On reset, the bank loads fixed defaults. Some of those defaults follow the video-standard pin.

Top module: `vcfg_wr_port`

## Requirements
- R1: With `id_alt_i`=0 the write ID is 42h; with `id_alt_i`=1 it is 1Ch. An I2C address byte equal to the write ID is acknowledged by `sda_oe_o`=1 during the ninth SCL high phase.
- R2: An I2C address byte that differs from the write ID (including the read-direction values 43h/1Dh) gets no acknowledge. The sub-address and data bytes that follow change no register and raise no strobe until the next START.
- R3: After a matched address, the I2C sub-address byte and every data byte are acknowledged. Each data byte (MSB first) is stored in the register at the current pointer.
- R4: The pointer advances by one after every data byte, so the bytes of a burst land in consecutive registers.
- R5: SPI frames run from a falling `spi_csn_i` to a rising `spi_csn_i`. Bits are sampled MSB first on the rising `spi_sck_i`. Byte 1 is the write ID, byte 2 is the sub-address, and the remaining bytes are data with auto-increment.
- R6: An SPI command byte that differs from the write ID makes the rest of that frame change nothing. The next frame is decoded normally.
- R7: A data byte aimed at a sub-address outside 70h..87h is acknowledged and dropped, and it gives no strobe. The pointer still advances, so a burst that starts below 70h continues into the bank.
- R8: Reset values are: 70h=01h, 71h=04h, 73h=80h, 83h..86h=80h, bits 5 and 3 of 72h set, and every other register 00h.
- R9: With `std_pal_i`=0 held through reset, 72h=28h, 74h=79 and 75h=128. With `std_pal_i`=1, 72h=2Dh (bits [2:0]=101), 74h=157 and 75h=107.
- R10: `wr_stb_o` pulses for exactly one cycle per stored byte, with `wr_addr_o` giving its sub-address. The pulse appears, and the new value shows on `regs_o`, 4 clock edges after the data byte's final SCL/SCK rise reaches the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| id_alt_i | input | 1 | Device ID select: 0 for 42h, 1 for 1Ch |
| std_pal_i | input | 1 | Video standard pin: 1 for PAL, 0 for NTSC defaults |
| scl_i | input | 1 | I2C clock |
| sda_i | input | 1 | I2C data as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) |
| spi_csn_i | input | 1 | SPI chip select, active low |
| spi_sck_i | input | 1 | SPI clock, idle low |
| spi_mosi_i | input | 1 | SPI data in |
| regs_o | output | NUM_REGS*8 | Register bank; byte k holds sub-address 70h+k |
| wr_stb_o | output | 1 | One-cycle pulse per stored byte |
| wr_addr_o | output | 8 | Sub-address of the stored byte |

## Verification
Two latencies matter here. A register update and its strobe are due 4 clock edges after the bench drives the last rising bus clock of a data byte. The acknowledge drive rises 3 edges after the eighth falling SCL. The bench drives all pins on falling clock edges and keeps a cycle counter. When a data byte completes, it schedules the model write at that count plus four. Every falling edge then compares the whole bank and the strobe against the model. Acknowledge is sampled four cycles into the ninth SCL high phase, well after it is due and before it can be released.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  typedef logic [7:0] byte_t;

  typedef struct packed {
    logic  sub_vld;
    logic  dat_vld;
    byte_t val;
  } wr_evt_t;

  typedef enum logic [2:0] {PH_IDLE, PH_ID, PH_SUB, PH_DATA, PH_SKIP} phase_e;

  function automatic byte_t dev_id(input logic alt);
    return alt ? 8'h1C : 8'h42;
  endfunction
endpackage

// File: rtl/vcfg_sync.sv
module vcfg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] pipe_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= {STAGES{RST_VAL}};
      last_q <= RST_VAL;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d_i};
      last_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = lvl_o & ~last_q;
  assign fall_o = ~lvl_o & last_q;
endmodule

// File: rtl/vcfg_i2c_rx.sv
module vcfg_i2c_rx
  import vcfg_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_lvl_i,
  input  logic    scl_rise_i,
  input  logic    scl_fall_i,
  input  logic    sda_lvl_i,
  input  logic    sda_rise_i,
  input  logic    sda_fall_i,
  input  byte_t   id_i,
  output wr_evt_t evt_o,
  output logic    sda_oe_o
);
  phase_e     ph_q;
  logic [3:0] cnt_q;
  byte_t      sh_q;
  logic       ack_q;
  byte_t      byte_nx;
  logic       start_c, stop_c;

  assign start_c = sda_fall_i & scl_lvl_i;
  assign stop_c  = sda_rise_i & scl_lvl_i;
  assign byte_nx = {sh_q[6:0], sda_lvl_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      ack_q <= 1'b0;
      evt_o <= '0;
    end else begin
      evt_o <= '0;
      if (start_c) begin
        ph_q  <= PH_ID;
        cnt_q <= '0;
        ack_q <= 1'b0;
      end else if (stop_c) begin
        ph_q  <= PH_IDLE;
        cnt_q <= '0;
        ack_q <= 1'b0;
      end else if (ph_q inside {PH_ID, PH_SUB, PH_DATA}) begin
        if (scl_rise_i && cnt_q < 4'd8) begin
          sh_q  <= byte_nx;
          cnt_q <= cnt_q + 4'd1;
          if (cnt_q == 4'd7) begin
            case (ph_q)
              PH_ID: if (byte_nx != id_i) begin
                ph_q  <= PH_SKIP;
                cnt_q <= '0;
              end
              PH_SUB: begin
                evt_o.sub_vld <= 1'b1;
                evt_o.val     <= byte_nx;
              end
              default: begin
                evt_o.dat_vld <= 1'b1;
                evt_o.val     <= byte_nx;
              end
            endcase
          end
        end else if (scl_fall_i && cnt_q == 4'd8) begin
          ack_q <= 1'b1;
          cnt_q <= 4'd9;
        end else if (scl_fall_i && cnt_q == 4'd9) begin
          ack_q <= 1'b0;
          cnt_q <= '0;
          if (ph_q == PH_ID) ph_q <= PH_SUB;
          else if (ph_q == PH_SUB) ph_q <= PH_DATA;
        end
      end
    end
  end

  assign sda_oe_o = ack_q;

  // R1: acknowledge drive starts only on an SCL falling edge
  p_ack_on_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(scl_fall_i));
  // R2: a rejected address produces no events
  p_skip_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SKIP) |=> !(evt_o.dat_vld || evt_o.sub_vld));
endmodule

// File: rtl/vcfg_spi_rx.sv
module vcfg_spi_rx
  import vcfg_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    csn_lvl_i,
  input  logic    csn_rise_i,
  input  logic    csn_fall_i,
  input  logic    sck_rise_i,
  input  logic    mosi_lvl_i,
  input  byte_t   id_i,
  output wr_evt_t evt_o
);
  phase_e     ph_q;
  logic [2:0] cnt_q;
  byte_t      sh_q;
  byte_t      byte_nx;

  assign byte_nx = {sh_q[6:0], mosi_lvl_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      evt_o <= '0;
    end else begin
      evt_o <= '0;
      if (csn_fall_i) begin
        ph_q  <= PH_ID;
        cnt_q <= '0;
      end else if (csn_rise_i) begin
        ph_q  <= PH_IDLE;
      end else if (!csn_lvl_i && sck_rise_i && (ph_q inside {PH_ID, PH_SUB, PH_DATA})) begin
        sh_q  <= byte_nx;
        cnt_q <= cnt_q + 3'd1;
        if (cnt_q == 3'd7) begin
          case (ph_q)
            PH_ID:  ph_q <= (byte_nx == id_i) ? PH_SUB : PH_SKIP;
            PH_SUB: begin
              evt_o.sub_vld <= 1'b1;
              evt_o.val     <= byte_nx;
              ph_q          <= PH_DATA;
            end
            default: begin
              evt_o.dat_vld <= 1'b1;
              evt_o.val     <= byte_nx;
            end
          endcase
        end
      end
    end
  end

  // R6: once rejected, a frame stays rejected until chip select moves
  p_skip_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SKIP && !csn_fall_i && !csn_rise_i) |=> (ph_q == PH_SKIP));
  // R5: a byte is either a sub-address or data, never both
  p_evt_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_o.sub_vld && evt_o.dat_vld));
endmodule

// File: rtl/vcfg_regbank.sv
module vcfg_regbank
  import vcfg_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h70,
  parameter int         NUM_REGS  = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  std_pal_i,
  input  wr_evt_t               evt_i,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  wr_stb_o,
  output logic [7:0]            wr_addr_o
);
  localparam int BASE_I = int'(BASE_ADDR);
  localparam int LAST_I = BASE_I + NUM_REGS - 1;

  function automatic byte_t dflt(input int addr, input logic pal);
    case (addr)
      'h70: return 8'h01;
      'h71: return 8'h04;
      'h72: return pal ? 8'h2D : 8'h28;
      'h73, 'h83, 'h84, 'h85, 'h86: return 8'h80;
      'h74: return pal ? 8'd157 : 8'd79;
      'h75: return pal ? 8'd107 : 8'd128;
      default: return 8'h00;
    endcase
  endfunction

  logic [NUM_REGS-1:0][7:0] regs_q;
  byte_t ptr_q;
  byte_t off_c;
  logic  hit_c;
  logic  stb_q;
  byte_t addr_q;

  assign off_c = ptr_q - BASE_ADDR;
  assign hit_c = evt_i.dat_vld && (int'(ptr_q) >= BASE_I) && (int'(ptr_q) <= LAST_I);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (evt_i.sub_vld) ptr_q <= evt_i.val;
    else if (evt_i.dat_vld) ptr_q <= ptr_q + 8'd1;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= dflt(BASE_I + g, std_pal_i);
      else if (hit_c && off_c == 8'(g)) regs_q[g] <= evt_i.val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      stb_q <= hit_c;
      if (hit_c) addr_q <= ptr_q;
    end
  end

  assign regs_o    = regs_q;
  assign wr_stb_o  = stb_q;
  assign wr_addr_o = addr_q;

  // R4: every data byte steps the pointer
  p_ptr_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.dat_vld && !evt_i.sub_vld) |=> (ptr_q == $past(ptr_q) + 8'd1));
  // R3: the bank only changes on a data byte
  p_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i.dat_vld |=> $stable(regs_o));
  // R10: a strobe always follows a data byte
  p_stb_after_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(evt_i.dat_vld));
endmodule

// File: rtl/vcfg_wr_port.sv
module vcfg_wr_port
  import vcfg_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR   = 8'h70,
  parameter int         NUM_REGS    = 24,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  id_alt_i,
  input  logic                  std_pal_i,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic                  spi_csn_i,
  input  logic                  spi_sck_i,
  input  logic                  spi_mosi_i,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  wr_stb_o,
  output logic [7:0]            wr_addr_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic csn_lvl, csn_rise, csn_fall;
  logic sck_lvl, sck_rise, sck_fall;
  logic mosi_lvl, mosi_rise, mosi_fall;
  logic unused_edges;
  byte_t   id_c;
  wr_evt_t i2c_evt, spi_evt, evt_c;

  vcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_scl (
    .clk_i, .rst_ni, .d_i(scl_i), .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));
  vcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_sda (
    .clk_i, .rst_ni, .d_i(sda_i), .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));
  vcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_csn (
    .clk_i, .rst_ni, .d_i(spi_csn_i), .lvl_o(csn_lvl), .rise_o(csn_rise), .fall_o(csn_fall));
  vcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sck (
    .clk_i, .rst_ni, .d_i(spi_sck_i), .lvl_o(sck_lvl), .rise_o(sck_rise), .fall_o(sck_fall));
  vcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_mosi (
    .clk_i, .rst_ni, .d_i(spi_mosi_i), .lvl_o(mosi_lvl), .rise_o(mosi_rise), .fall_o(mosi_fall));

  assign unused_edges = ^{sck_lvl, sck_fall, mosi_rise, mosi_fall};
  assign id_c = dev_id(id_alt_i);

  vcfg_i2c_rx i_i2c (
    .clk_i, .rst_ni,
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .id_i(id_c), .evt_o(i2c_evt), .sda_oe_o(sda_oe_o));

  vcfg_spi_rx i_spi (
    .clk_i, .rst_ni,
    .csn_lvl_i(csn_lvl), .csn_rise_i(csn_rise), .csn_fall_i(csn_fall),
    .sck_rise_i(sck_rise), .mosi_lvl_i(mosi_lvl),
    .id_i(id_c), .evt_o(spi_evt));

  // I2C wins if both front-ends complete a byte in the same cycle
  assign evt_c = (i2c_evt.sub_vld || i2c_evt.dat_vld) ? i2c_evt : spi_evt;

  vcfg_regbank #(.BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS)) i_bank (
    .clk_i, .rst_ni, .std_pal_i, .evt_i(evt_c),
    .regs_o, .wr_stb_o, .wr_addr_o);
endmodule

// File: tb/test_vcfg_wr_port.sv
`timescale 1ns/1ps
module test_vcfg_wr_port;
  localparam int NR   = 24;
  localparam int BASE = 'h70;
  localparam int H    = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, id_alt = 1'b0, pal = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1, csn = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic sda_oe, sda_line, wr_stb;
  logic [7:0] wr_addr;
  logic [NR*8-1:0] regs;

  assign sda_line = sda_drv & ~sda_oe;

  vcfg_wr_port i_vcfg_wr_port (
    .clk_i(clk), .rst_ni(rst_n), .id_alt_i(id_alt), .std_pal_i(pal),
    .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .spi_csn_i(csn), .spi_sck_i(sck), .spi_mosi_i(mosi),
    .regs_o(regs), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr));

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit chk_en = 1'b0;
  string req = "R8";
  int model[NR];
  int mptr = 0;
  int pq_cyc[$], pq_adr[$], pq_dat[$];
  bit e_stb;
  int e_adr;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string r, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  task automatic set_defaults(input bit p);
    for (int i = 0; i < NR; i++) model[i] = 0;
    model['h70-BASE] = 'h01;
    model['h71-BASE] = 'h04;
    model['h72-BASE] = p ? 'h2D : 'h28;
    model['h73-BASE] = 'h80;
    model['h74-BASE] = p ? 157 : 79;
    model['h75-BASE] = p ? 107 : 128;
    for (int a = 'h83; a <= 'h86; a++) model[a-BASE] = 'h80;
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_en) begin
      e_stb = 1'b0;
      e_adr = 0;
      while (pq_cyc.size() > 0 && pq_cyc[0] <= cyc) begin
        model[pq_adr[0]-BASE] = pq_dat[0];
        e_stb = (pq_cyc[0] == cyc);
        e_adr = pq_adr[0];
        void'(pq_cyc.pop_front());
        void'(pq_adr.pop_front());
        void'(pq_dat.pop_front());
      end
      for (int i = 0; i < NR; i++)
        chk(req, $sformatf("reg %0h", BASE + i), int'(regs[8*i +: 8]), model[i]);
      chk("R10", "strobe", int'(wr_stb), int'(e_stb));
      if (e_stb) chk("R10", "strobe addr", int'(wr_addr), e_adr);
    end
  end

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  // mode: 0 none, 1 sub-address, 2 data
  task automatic model_byte(input int b, input int mode);
    if (mode == 1) mptr = b;
    else if (mode == 2) begin
      if (mptr >= BASE && mptr < BASE + NR) begin
        pq_cyc.push_back(cyc + 4);
        pq_adr.push_back(mptr);
        pq_dat.push_back(b);
      end
      mptr = (mptr + 1) & 'hFF;
    end
  endtask

  task automatic do_reset(input bit p);
    chk_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    pal = p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    set_defaults(p);
    pq_cyc.delete(); pq_adr.delete(); pq_dat.delete();
    mptr = 0;
    @(negedge clk);
    chk_en = 1'b1;
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; half();
    scl = 1'b1; half();
    sda_drv = 1'b0; half();
    scl = 1'b0; half();
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; half();
    scl = 1'b1; half();
    sda_drv = 1'b1; half();
  endtask

  task automatic i2c_byte(input int b, input int mode, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; half();
      scl = 1'b1;
      if (i == 0) model_byte(b, mode);
      half();
      scl = 1'b0; half();
    end
    sda_drv = 1'b1; half();
    scl = 1'b1;
    repeat (4) @(negedge clk);
    acked = sda_oe;
    repeat (H - 4) @(negedge clk);
    scl = 1'b0; half();
  endtask

  task automatic i2c_write(input string r, input int adr, input bit ok,
                           input int sub, input int d[8], input int n);
    bit a;
    i2c_start();
    i2c_byte(adr, 0, a);
    chk(r, "address ack", int'(a), int'(ok));
    i2c_byte(sub, ok ? 1 : 0, a);
    chk(r, "sub ack", int'(a), int'(ok));
    for (int k = 0; k < n; k++) begin
      i2c_byte(d[k], ok ? 2 : 0, a);
      chk(r, "data ack", int'(a), int'(ok));
    end
    i2c_stop();
  endtask

  task automatic spi_byte(input int b, input int mode);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i]; half();
      sck = 1'b1;
      if (i == 0) model_byte(b, mode);
      half();
      sck = 1'b0;
    end
  endtask

  task automatic spi_frame(input int cmd, input bit ok, input int sub,
                           input int d[8], input int n);
    csn = 1'b0; half();
    spi_byte(cmd, 0);
    spi_byte(sub, ok ? 1 : 0);
    for (int k = 0; k < n; k++) spi_byte(d[k], ok ? 2 : 0);
    half();
    csn = 1'b1; half();
  endtask

  task automatic finish_run();
    chk_en = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d[8];
    // R8, R9: NTSC defaults
    req = "R8";
    do_reset(1'b0);
    @(negedge clk);
    chk("R8", "reg 70", int'(regs[7:0]), 'h01);
    chk("R9", "reg 72 ntsc", int'(regs[8*2 +: 8]), 'h28);
    chk("R9", "reg 74 ntsc", int'(regs[8*4 +: 8]), 79);
    chk("R8", "reg 86", int'(regs[8*('h86-BASE) +: 8]), 'h80);
    chk("R10", "no strobe after reset", int'(wr_stb), 0);
    half();

    // R1, R3, R4: I2C burst with ID 42h
    req = "R4";
    d = '{'h11, 'h22, 'h33, 0, 0, 0, 0, 0};
    i2c_write("R1", 'h42, 1'b1, 'h76, d, 3);
    repeat (8) @(negedge clk);

    // R2: read-direction address and foreign address are rejected
    req = "R2";
    d = '{'hDE, 'hAD, 0, 0, 0, 0, 0, 0};
    i2c_write("R2", 'h43, 1'b0, 'h70, d, 2);
    i2c_write("R2", 'h1C, 1'b0, 'h71, d, 1);
    repeat (8) @(negedge clk);

    // R2: the next START decodes normally again
    req = "R3";
    d = '{'h5A, 0, 0, 0, 0, 0, 0, 0};
    i2c_write("R3", 'h42, 1'b1, 'h87, d, 1);

    // R1: alternate ID 1Ch
    id_alt = 1'b1;
    req = "R1";
    d = '{'hA5, 'h3C, 0, 0, 0, 0, 0, 0};
    i2c_write("R1", 'h1C, 1'b1, 'h80, d, 2);
    i2c_write("R1", 'h42, 1'b0, 'h80, d, 1);

    // R7: burst that starts below the bank and one that runs past its top
    req = "R7";
    d = '{'h01, 'h02, 'h03, 'h04, 0, 0, 0, 0};
    i2c_write("R7", 'h1C, 1'b1, 'h6E, d, 4);
    d = '{'hC1, 'hC2, 'hC3, 0, 0, 0, 0, 0};
    i2c_write("R7", 'h1C, 1'b1, 'h86, d, 3);

    // R5: SPI burst with ID 1Ch, then with ID 42h
    req = "R5";
    d = '{'h9A, 'h9B, 'h9C, 0, 0, 0, 0, 0};
    spi_frame('h1C, 1'b1, 'h77, d, 3);
    id_alt = 1'b0;
    d = '{'h44, 'h55, 0, 0, 0, 0, 0, 0};
    spi_frame('h42, 1'b1, 'h7E, d, 2);

    // R6: rejected command byte, then a good frame
    req = "R6";
    d = '{'hEE, 'hEF, 0, 0, 0, 0, 0, 0};
    spi_frame('h1C, 1'b0, 'h72, d, 2);
    spi_frame('h43, 1'b0, 'h73, d, 1);
    d = '{'h66, 0, 0, 0, 0, 0, 0, 0};
    spi_frame('h42, 1'b1, 'h85, d, 1);

    // R7 on SPI: out-of-range bytes still step the pointer
    req = "R7";
    d = '{'h10, 'h20, 0, 0, 0, 0, 0, 0};
    spi_frame('h42, 1'b1, 'h6F, d, 2);
    repeat (8) @(negedge clk);

    // R9: PAL defaults
    req = "R9";
    do_reset(1'b1);
    @(negedge clk);
    chk("R9", "reg 72 pal", int'(regs[8*2 +: 8]), 'h2D);
    chk("R9", "reg 74 pal", int'(regs[8*4 +: 8]), 157);
    chk("R9", "reg 75 pal", int'(regs[8*5 +: 8]), 107);
    chk("R8", "reg 73", int'(regs[8*3 +: 8]), 'h80);
    req = "R3";
    d = '{'h77, 0, 0, 0, 0, 0, 0, 0};
    i2c_write("R3", 'h42, 1'b1, 'h74, d, 1);
    repeat (8) @(negedge clk);

    finish_run();
  end
endmodule